// File: doc/BRIEF.md
# Soft-Response Decision Unit for a Capacitor-Mismatch PUF

This block turns repeated raw bits from a physical unclonable function into one final decision for a single challenge. Each accepted request makes it ask an external evaluation sequencer for a run-time number of evaluations, N. It counts how many of them come back as 1 and then compares that count with thresholds chosen by the mode. No division is used: every comparison is an integer comparison against N.

In enrollment mode the block reports a bit and a keep flag. A challenge whose ones count falls inside a marginal band is reported as discarded. The keep flag is the per-challenge helper data that a host stores. In authentication mode the host marks a challenge as discarded when the stored helper data says so. Such a challenge is skipped at once and no evaluations are run for it. Every other challenge is decided at the midpoint and its bit is packed into a 128-bit response word.

Top module: `soft_resp_decider`

## Requirements
- R1: After a synchronous reset, `busy`, `eval_req`, `done` and `word_valid` are all low.
- R2: A `start` seen while idle latches `mode_auth`, `cfg_reps`, `cfg_lo_tenths` and `cfg_hi_tenths`. It then gets exactly N acknowledged evaluations, where N = `cfg_reps`, or 1 when `cfg_reps` is 0. `eval_req` stays high until the N-th `eval_ack`. An `eval_ack` while `eval_req` is low is ignored.
- R3: The ones count is the number of acknowledged evaluations whose `eval_bit` was 1.
- R4: In enrollment mode (`mode_auth`=0), when count*10 <= N*lo the result is `res_keep`=1 and `res_bit`=0. This zero test wins if both tests hold.
- R5: In enrollment mode, when count*10 >= N*hi and the R4 test fails, the result is `res_keep`=1 and `res_bit`=1.
- R6: In enrollment mode, when neither test holds, the challenge is discarded with `res_keep`=0 and `res_bit`=0.
- R7: In authentication mode (`mode_auth`=1) with `helper_discard`=0, `res_bit` is 1 exactly when count*2 > N, and `res_keep` is 1.
- R8: In authentication mode with `helper_discard`=1, `eval_req` never rises. `done` pulses in the cycle after `start` with `res_keep`=0 and `res_bit`=0.
- R9: Every accepted `start` gives exactly one one-cycle `done` pulse. The results hold until the next `done`.
- R10: A `start` while `busy` is high is ignored, as are changes to the mode and config inputs. The running challenge keeps its N, its thresholds and its outcome, and no extra `done` appears.
- R11: Only authentication results that were evaluated are packed. Each packed bit enters at bit 127 and shifts toward bit 0, so the first bit of a word ends up in bit 0. `word_valid` pulses in the same cycle as the `done` of the 128th bit, and `word_data` then holds the full word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin deciding one challenge |
| mode_auth | input | 1 | 0 enrollment, 1 authentication |
| helper_discard | input | 1 | Stored helper flag: challenge was discarded at enrollment |
| cfg_reps | input | 8 | Evaluations per challenge (0 treated as 1) |
| cfg_lo_tenths | input | 4 | Enrollment zero threshold in tenths |
| cfg_hi_tenths | input | 4 | Enrollment one threshold in tenths |
| busy | output | 1 | Evaluation in progress |
| eval_req | output | 1 | Request to the evaluation sequencer |
| eval_ack | input | 1 | One evaluation finished |
| eval_bit | input | 1 | Raw comparator bit of that evaluation |
| done | output | 1 | One-cycle result strobe |
| res_bit | output | 1 | Decided bit |
| res_keep | output | 1 | 1 keep / 0 discard |
| word_valid | output | 1 | 128-bit response word complete |
| word_data | output | 128 | Packed authentication bits |

## Verification
Suppose the evaluation counter miscounts or ends early. The next `done` then shows a result bit or keep flag that disagrees with the count the bench chose, and the bench also sees a different number of acknowledgements. A missed or extra shift in the packer goes unseen until the end of the word. It then shows up as a `word_valid` pulse on the wrong challenge or as a whole-word mismatch, up to 128 challenges later. A wrong skip path shows as an `eval_req` or a late `done` in the cycle after `start`.

// File: rtl/srd_pkg.sv
package srd_pkg;
  typedef enum logic {
    MODE_ENROLL = 1'b0,
    MODE_AUTH   = 1'b1
  } srd_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } srd_state_e;
endpackage

// File: rtl/srd_eval_counter.sv
module srd_eval_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             launch,
  input  logic [CNT_W-1:0] n_reps,
  input  logic             eval_ack,
  input  logic             eval_bit,
  output logic             eval_req,
  output logic [CNT_W-1:0] ones,
  output logic             fin
);
  logic [CNT_W-1:0] issued;
  logic [CNT_W:0]   issued_nx;

  assign issued_nx = {1'b0, issued} + (CNT_W+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      eval_req <= 1'b0;
      ones     <= '0;
      issued   <= '0;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (launch) begin
        eval_req <= 1'b1;
        ones     <= '0;
        issued   <= '0;
      end else if (eval_req && eval_ack) begin
        ones   <= ones + CNT_W'(eval_bit);
        issued <= issued_nx[CNT_W-1:0];
        if (issued_nx == {1'b0, n_reps}) begin
          eval_req <= 1'b0;
          fin      <= 1'b1;
        end
      end
    end
  end

  AST_ONES_BOUND: assert property (@(posedge clk) disable iff (rst)
    ones <= issued); // R3
  AST_FIN_COUNT: assert property (@(posedge clk) disable iff (rst)
    fin |-> (issued == n_reps)); // R2
  AST_FIN_DROPS_REQ: assert property (@(posedge clk) disable iff (rst)
    fin |-> !eval_req); // R2
endmodule

// File: rtl/srd_classifier.sv
module srd_classifier #(
  parameter int CNT_W = 8,
  parameter int THR_W = 4,
  parameter int SCALE = 10
) (
  input  logic             mode_auth,
  input  logic [CNT_W-1:0] ones,
  input  logic [CNT_W-1:0] n_reps,
  input  logic [THR_W-1:0] lo_thr,
  input  logic [THR_W-1:0] hi_thr,
  output logic             bit_o,
  output logic             keep_o
);
  localparam int PROD_W = CNT_W + THR_W + 1;

  logic [PROD_W-1:0] ones_scaled, lo_lim, hi_lim, ones_dbl, n_w;
  logic zero_ok, one_ok, mid_one;

  always_comb begin
    ones_scaled = PROD_W'(ones) * PROD_W'(SCALE);
    lo_lim      = PROD_W'(n_reps) * PROD_W'(lo_thr);
    hi_lim      = PROD_W'(n_reps) * PROD_W'(hi_thr);
    ones_dbl    = PROD_W'(ones) << 1;
    n_w         = PROD_W'(n_reps);
    zero_ok     = (ones_scaled <= lo_lim);
    one_ok      = (ones_scaled >= hi_lim);
    mid_one     = (ones_dbl > n_w);
    if (mode_auth) begin
      bit_o  = mid_one;
      keep_o = 1'b1;
    end else begin
      keep_o = zero_ok | one_ok;
      bit_o  = one_ok & ~zero_ok;
    end
  end
endmodule

// File: rtl/srd_word_packer.sv
module srd_word_packer #(
  parameter int WORD_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              bit_in,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic [IDX_W-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      fill       <= '0;
      word_valid <= 1'b0;
      word_data  <= '0;
    end else begin
      word_valid <= 1'b0;
      if (push) begin
        word_data <= {bit_in, word_data[WORD_W-1:1]};
        if (fill == LAST) begin
          fill       <= '0;
          word_valid <= 1'b1;
        end else begin
          fill <= fill + IDX_W'(1);
        end
      end
    end
  end

  AST_WORD_SPACING: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid); // R11
  AST_VALID_AFTER_PUSH: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> $past(push)); // R11
endmodule

// File: rtl/soft_resp_decider.sv
module soft_resp_decider #(
  parameter int CNT_W  = 8,
  parameter int THR_W  = 4,
  parameter int SCALE  = 10,
  parameter int WORD_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_auth,
  input  logic              helper_discard,
  input  logic [CNT_W-1:0]  cfg_reps,
  input  logic [THR_W-1:0]  cfg_lo_tenths,
  input  logic [THR_W-1:0]  cfg_hi_tenths,
  output logic              busy,
  output logic              eval_req,
  input  logic              eval_ack,
  input  logic              eval_bit,
  output logic              done,
  output logic              res_bit,
  output logic              res_keep,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data
);
  import srd_pkg::*;

  srd_state_e       state;
  srd_mode_e        mode_q;
  logic [CNT_W-1:0] n_q;
  logic [THR_W-1:0] lo_q, hi_q;
  logic [CNT_W-1:0] n_eff, ones;
  logic             accept, skip, launch, fin, cls_bit, cls_keep, push;

  assign n_eff  = (cfg_reps == '0) ? CNT_W'(1) : cfg_reps;
  assign accept = start && (state == ST_IDLE);
  assign skip   = accept && mode_auth && helper_discard;
  assign launch = accept && !skip;
  assign busy   = (state == ST_RUN);
  assign push   = fin && (mode_q == MODE_AUTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      mode_q   <= MODE_ENROLL;
      n_q      <= CNT_W'(1);
      lo_q     <= '0;
      hi_q     <= '0;
      done     <= 1'b0;
      res_bit  <= 1'b0;
      res_keep <= 1'b0;
    end else begin
      done <= 1'b0;
      if (skip) begin
        done     <= 1'b1;
        res_bit  <= 1'b0;
        res_keep <= 1'b0;
      end else if (launch) begin
        state  <= ST_RUN;
        mode_q <= srd_mode_e'(mode_auth);
        n_q    <= n_eff;
        lo_q   <= cfg_lo_tenths;
        hi_q   <= cfg_hi_tenths;
      end else if (fin) begin
        state    <= ST_IDLE;
        done     <= 1'b1;
        res_bit  <= cls_bit;
        res_keep <= cls_keep;
      end
    end
  end

  srd_eval_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst(rst), .launch(launch), .n_reps(n_q),
    .eval_ack(eval_ack), .eval_bit(eval_bit),
    .eval_req(eval_req), .ones(ones), .fin(fin)
  );

  srd_classifier #(.CNT_W(CNT_W), .THR_W(THR_W), .SCALE(SCALE)) u_classifier (
    .mode_auth(mode_q == MODE_AUTH), .ones(ones), .n_reps(n_q),
    .lo_thr(lo_q), .hi_thr(hi_q), .bit_o(cls_bit), .keep_o(cls_keep)
  );

  srd_word_packer #(.WORD_W(WORD_W)) u_packer (
    .clk(clk), .rst(rst), .push(push), .bit_in(cls_bit),
    .word_valid(word_valid), .word_data(word_data)
  );

  AST_SKIP_NO_EVAL: assert property (@(posedge clk) disable iff (rst)
    skip |=> (done && !res_keep && !eval_req && !busy)); // R8
  AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    eval_req |-> busy); // R2
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R9
  AST_CFG_HELD: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(n_q) && $stable(mode_q))); // R10
  AST_WORD_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (done && res_keep)); // R11
endmodule

// File: tb/test_soft_resp_decider.sv
module test_soft_resp_decider;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0, mode_auth = 1'b0, helper_discard = 1'b0;
  logic [7:0]   cfg_reps = 8'd1;
  logic [3:0]   cfg_lo_tenths = 4'd1, cfg_hi_tenths = 4'd9;
  logic         busy, eval_req, done, res_bit, res_keep, word_valid;
  logic         eval_ack = 1'b0, eval_bit = 1'b0;
  logic [127:0] word_data;

  int n_checks = 0, n_fail = 0;
  int ones_left = 0, total_left = 0, ack_cnt = 0, gap = 0;
  bit spurious = 1'b0;
  logic [127:0] model_word = '0;
  int model_fill = 0;

  always #4 clk = ~clk;

  soft_resp_decider i_soft_resp_decider (
    .clk(clk), .rst(rst), .start(start), .mode_auth(mode_auth),
    .helper_discard(helper_discard), .cfg_reps(cfg_reps),
    .cfg_lo_tenths(cfg_lo_tenths), .cfg_hi_tenths(cfg_hi_tenths),
    .busy(busy), .eval_req(eval_req), .eval_ack(eval_ack), .eval_bit(eval_bit),
    .done(done), .res_bit(res_bit), .res_keep(res_keep),
    .word_valid(word_valid), .word_data(word_data)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // evaluation sequencer model
  initial begin
    forever begin
      @(negedge clk);
      eval_ack = 1'b0;
      if (spurious) begin
        eval_ack = 1'b1;
        eval_bit = 1'b1;
      end else if (eval_req && gap == 0) begin
        eval_ack = 1'b1;
        eval_bit = 1'b0;
        if (total_left > 0) begin
          if (($urandom % total_left) < ones_left) begin
            eval_bit = 1'b1;
            ones_left--;
          end
          total_left--;
        end
        ack_cnt++;
        gap = $urandom % 3;
      end else if (gap > 0) begin
        gap--;
      end
    end
  end

  function automatic void expect_res(input logic m, input int n, input int k,
                                     input int lo, input int hi,
                                     output logic b, output logic keep);
    bit z, o;
    if (m) begin
      b = (2 * k > n);
      keep = 1'b1;
    end else begin
      z = (k * 10 <= n * lo);
      o = (k * 10 >= n * hi);
      keep = z | o;
      b = o & !z;
    end
  endfunction

  task automatic run(input logic m, input logic helper, input int n, input int k,
                     input int lo, input int hi, input bit poke);
    int ne, kk, cyc;
    logic eb, ek, ewv;
    ne = (n == 0) ? 1 : n;
    kk = (k > ne) ? ne : k;
    ones_left = kk; total_left = ne; ack_cnt = 0; gap = $urandom % 2;
    @(negedge clk);
    start = 1'b1; mode_auth = m; helper_discard = helper;
    cfg_reps = 8'(n); cfg_lo_tenths = 4'(lo); cfg_hi_tenths = 4'(hi);
    @(negedge clk);
    start = 1'b0;
    // R10: scramble inputs while the challenge runs
    cfg_reps = 8'($urandom); cfg_lo_tenths = 4'($urandom); cfg_hi_tenths = 4'($urandom);
    mode_auth = !m; helper_discard = 1'($urandom);
    cyc = 0;
    while (!done && cyc < 3000) begin
      start = poke && (cyc == 1);
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk("R9 done seen", 128'(done), 128'(1));
    if (m && helper) begin
      chk("R8 skip cycle", 128'(cyc), 128'(0));
      chk("R8 skip no evals", 128'(ack_cnt), 128'(0));
      chk("R8 skip keep", 128'(res_keep), 128'(0));
      chk("R8 skip bit", 128'(res_bit), 128'(0));
      chk("R11 no word on skip", 128'(word_valid), 128'(0));
    end else begin
      expect_res(m, ne, kk, lo, hi, eb, ek);
      chk("R2 eval count", 128'(ack_cnt), 128'(ne));
      if (m) chk("R7 auth bit", 128'(res_bit), 128'(eb));
      else if (!ek) chk("R6 discard bit", 128'(res_bit), 128'(0));
      else if (eb) chk("R5 enroll one", 128'(res_bit), 128'(1));
      else chk("R4 enroll zero", 128'(res_bit), 128'(0));
      chk(m ? "R7 auth keep" : "R6 enroll keep", 128'(res_keep), 128'(ek));
      ewv = 1'b0;
      if (m) begin
        model_word = {eb, model_word[127:1]};
        model_fill++;
        if (model_fill == 128) begin
          ewv = 1'b1;
          model_fill = 0;
        end
      end
      chk("R11 word_valid", 128'(word_valid), 128'(ewv));
      if (ewv) chk("R11 word_data", word_data, model_word);
    end
    @(negedge clk);
    chk("R9 single done", 128'(done), 128'(0));
    chk("R10 no restart", 128'(busy), 128'(0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int n, k, lo, hi;
    logic m, h;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R1 busy", 128'(busy), 128'(0));
    chk("R1 eval_req", 128'(eval_req), 128'(0));
    chk("R1 done", 128'(done), 128'(0));
    chk("R1 word_valid", 128'(word_valid), 128'(0));
    rst = 1'b0;
    @(negedge clk);
    // R2: acknowledges while idle are ignored
    spurious = 1'b1;
    repeat (3) @(negedge clk);
    spurious = 1'b0;
    chk("R2 idle ack ignored", 128'(busy), 128'(0));
    run(1'b0, 1'b0, 10, 0, 1, 9, 1'b0);
    // directed thresholds with N=100
    run(1'b0, 1'b0, 100, 10, 1, 9, 1'b0);  // R4 boundary
    run(1'b0, 1'b0, 100, 11, 1, 9, 1'b0);  // R6
    run(1'b0, 1'b0, 100, 89, 1, 9, 1'b0);  // R6
    run(1'b0, 1'b0, 100, 90, 1, 9, 1'b1);  // R5 boundary, R10 poke
    run(1'b0, 1'b0, 10, 5, 6, 4, 1'b0);    // R4 priority when both hold
    run(1'b1, 1'b0, 100, 50, 1, 9, 1'b0);  // R7 midpoint -> 0
    run(1'b1, 1'b0, 100, 51, 1, 9, 1'b1);  // R7 -> 1
    run(1'b1, 1'b1, 100, 51, 1, 9, 1'b0);  // R8
    run(1'b1, 1'b0, 0, 1, 1, 9, 1'b0);     // R2 zero reps
    run(1'b0, 1'b0, 255, 255, 1, 9, 1'b0); // R5 max
    run(1'b1, 1'b0, 255, 128, 1, 9, 1'b0); // R7 odd N
    for (int i = 0; i < 420; i++) begin
      m  = ($urandom % 10) < 7;
      h  = m && (($urandom % 5) == 0);
      n  = 1 + ($urandom % 20);
      if (($urandom % 40) == 0) n = 0;
      k  = $urandom % (n + 1);
      if (($urandom % 3) == 0) k = (($urandom % 2) == 0) ? 0 : n;
      lo = 1; hi = 9;
      if (($urandom % 4) == 0) begin lo = $urandom % 16; hi = $urandom % 16; end
      run(m, h, n, k, lo, hi, ($urandom % 4) == 0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule